// File: doc/BRIEF.md
# System Control Register File

This block is a word-addressed bank of 32-bit control and status registers that sits on a simple single-cycle peripheral bus inside a small SoC. It decodes a 4 KB address window into 512 storage words. Software may write and read back any word. A handful of words come up holding fixed identification values after reset, and every other word comes up as zero.

One command word doubles as a trigger. Writing a restart code to it produces a one-cycle system reset request pulse, and writing a power-off code produces a one-cycle shutdown request pulse. The written value is stored as well. Three status words always read with two extra status bits set. Those bits are added on the read path only and are never stored. What the rest of the chip does with the two pulses is outside this block.

Top module: `sysctl_regfile`

## Requirements
- R1: Storage is 512 words of 32 bits. The word index is `bus_addr[10:2]`, so byte offsets 0x800 and above alias the lower half. Address bits [1:0] are ignored.
- R2: An access is taken when `bus_sel` is 1. `bus_write`=1 makes it a write and `bus_write`=0 makes it a read. Read data appears on `bus_rdata` one cycle after the read is taken and holds until the next read.
- R3: A write to byte offset 0xF00 (bits [11:2] compared) with data 0x00000001 or 0x00000002 raises `sys_reset_req` for exactly the next cycle.
- R4: A write to byte offset 0xF00 with data 0x00000003 raises `sys_halt_req` for exactly the next cycle. Any other data raises neither pulse, and the two pulses are never high together.
- R5: A write to byte offset 0xF00 also stores its data into the word it indexes, as every other write does.
- R6: A read of byte offset 0x100, 0x108 or 0x10C (bits [11:2] compared) returns the stored word ORed with 0x30000000. The stored word is not changed, so the same word read through its alias 0x900, 0x908 or 0x90C shows the raw value.
- R7: A read of any other offset, 0x104 included, returns exactly the stored word.
- R8: After reset, word index 0x40 holds 0x05F20121, 0x41 holds 0x00000002, 0x42 holds 0x05F30121 and 0x43 holds 0x05F40121. Every other word holds zero.
- R9: Reset is synchronous and active high. While it is applied, `bus_rdata`, `sys_reset_req` and `sys_halt_req` are 0 and writes are ignored. After reset, all words read their R8 values again, even words that were written before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset in the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| sys_reset_req | output | 1 | One-cycle system reset request |
| sys_halt_req | output | 1 | One-cycle shutdown request |

## Verification
Read data and both request pulses are due exactly one clock after the accepting edge. The bench drives on falling edges, so every result is sampled at the falling edge that follows the accepting rising edge. A monitor notes each read taken at a rising edge and compares it, half a cycle later, with the oldest entry in the expected-value queue. The write task checks the pulse outputs at that same falling edge, then checks one edge later that the pulse has dropped. A separate check of the read data several idle cycles after a read confirms that it holds.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam logic [31:0] ID_WORD_A   = 32'h05F2_0121;
  localparam logic [31:0] ID_WORD_B   = 32'h0000_0002;
  localparam logic [31:0] ID_WORD_C   = 32'h05F3_0121;
  localparam logic [31:0] ID_WORD_D   = 32'h05F4_0121;
  localparam int unsigned ID_BASE_IDX = 32'h40;

  typedef enum logic [1:0] {
    ACT_NONE    = 2'd0,
    ACT_RESTART = 2'd1,
    ACT_HALT    = 2'd2
  } cmd_action_e;

  // Power-on content of a word, by word index.
  function automatic logic [31:0] id_word(input int unsigned idx);
    logic [31:0] v;
    v = '0;
    if (idx == ID_BASE_IDX)     v = ID_WORD_A;
    if (idx == ID_BASE_IDX + 1) v = ID_WORD_B;
    if (idx == ID_BASE_IDX + 2) v = ID_WORD_C;
    if (idx == ID_BASE_IDX + 3) v = ID_WORD_D;
    return v;
  endfunction

  // Maps written command data to the request it raises.
  function automatic cmd_action_e decode_cmd(input logic [31:0] d);
    cmd_action_e a;
    case (d)
      32'd1, 32'd2: a = ACT_RESTART;
      32'd3:        a = ACT_HALT;
      default:      a = ACT_NONE;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/sysctl_store.sv
module sysctl_store #(
  parameter int unsigned WORDS  = 512,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_word
);
  import sysctl_pkg::*;

  // Plain array with no reset, so it can map onto block RAM.
  logic [DATA_W-1:0] mem [WORDS];
  // One flop per word: set once the word has been written since reset.
  logic [WORDS-1:0]  touched;

  logic [DATA_W-1:0] mem_q;
  logic [DATA_W-1:0] dflt_q;
  logic              touched_q;

  always_ff @(posedge clk) begin
    if (wr_en && !rst) begin
      mem[wr_idx] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      mem_q <= mem[rd_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      touched <= '0;
    end else if (wr_en) begin
      touched[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      touched_q <= 1'b0;
      dflt_q    <= '0;
    end else if (rd_en) begin
      touched_q <= touched[rd_idx];
      dflt_q    <= DATA_W'(id_word(int'(rd_idx)));
    end
  end

  assign rd_word = touched_q ? mem_q : dflt_q;

endmodule

// File: rtl/sysctl_cmd.sv
module sysctl_cmd #(
  parameter int unsigned WA_W   = 10,
  parameter int unsigned DATA_W = 32,
  parameter logic [WA_W-1:0] CMD_WADDR = 10'h3C0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WA_W-1:0]   wr_waddr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              restart_req,
  output logic              halt_req
);
  import sysctl_pkg::*;

  cmd_action_e act;

  always_comb begin
    act = ACT_NONE;
    if (wr_en && (wr_waddr == CMD_WADDR)) begin
      act = decode_cmd(32'(wr_data));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      restart_req <= 1'b0;
      halt_req    <= 1'b0;
    end else begin
      restart_req <= (act == ACT_RESTART);
      halt_req    <= (act == ACT_HALT);
    end
  end

endmodule

// File: rtl/sysctl_rdpath.sv
module sysctl_rdpath #(
  parameter int unsigned WA_W     = 10,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_STAT = 3,
  parameter logic [NUM_STAT*WA_W-1:0] STAT_WADDRS = {10'h043, 10'h042, 10'h040},
  parameter logic [DATA_W-1:0] FORCE_MASK = 32'h3000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [WA_W-1:0]   rd_waddr,
  input  logic [DATA_W-1:0] word_in,
  output logic [DATA_W-1:0] rdata
);
  logic [NUM_STAT-1:0] stat_hit;
  logic                force_q;

  for (genvar k = 0; k < NUM_STAT; k++) begin : g_stat
    assign stat_hit[k] = (rd_waddr == STAT_WADDRS[k*WA_W +: WA_W]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      force_q <= 1'b0;
    end else if (rd_en) begin
      force_q <= |stat_hit;
    end
  end

  assign rdata = word_in | (force_q ? FORCE_MASK : '0);

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned WORDS    = 512,
  parameter int unsigned NUM_STAT = 3,
  parameter logic [ADDR_W-1:0] CMD_OFFSET = 12'hF00,
  parameter logic [NUM_STAT*ADDR_W-1:0] STAT_OFFSETS = {12'h10C, 12'h108, 12'h100},
  parameter logic [DATA_W-1:0] FORCE_MASK = 32'h3000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sys_reset_req,
  output logic              sys_halt_req
);
  localparam int unsigned IDX_W = $clog2(WORDS);
  localparam int unsigned WA_W  = ADDR_W - 2;

  function automatic logic [NUM_STAT*WA_W-1:0] to_waddrs(
      input logic [NUM_STAT*ADDR_W-1:0] offs);
    logic [NUM_STAT*WA_W-1:0] r;
    for (int k = 0; k < NUM_STAT; k++) begin
      r[k*WA_W +: WA_W] = offs[k*ADDR_W + 2 +: WA_W];
    end
    return r;
  endfunction

  localparam logic [NUM_STAT*WA_W-1:0] STAT_WADDRS = to_waddrs(STAT_OFFSETS);
  localparam logic [WA_W-1:0]          CMD_WADDR   = CMD_OFFSET[ADDR_W-1:2];

  logic              wr_en;
  logic              rd_en;
  logic [WA_W-1:0]   waddr;
  logic [IDX_W-1:0]  widx;
  logic [DATA_W-1:0] stored_word;
  logic              unused_lane_bits;

  assign wr_en = bus_sel && bus_write;
  assign rd_en = bus_sel && !bus_write;
  assign waddr = bus_addr[ADDR_W-1:2];
  assign widx  = bus_addr[IDX_W+1:2];
  assign unused_lane_bits = ^bus_addr[1:0];

  sysctl_store #(
    .WORDS (WORDS),
    .DATA_W(DATA_W)
  ) u_store (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_idx (widx),
    .wr_data(bus_wdata),
    .rd_en  (rd_en),
    .rd_idx (widx),
    .rd_word(stored_word)
  );

  sysctl_cmd #(
    .WA_W     (WA_W),
    .DATA_W   (DATA_W),
    .CMD_WADDR(CMD_WADDR)
  ) u_cmd (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_waddr   (waddr),
    .wr_data    (bus_wdata),
    .restart_req(sys_reset_req),
    .halt_req   (sys_halt_req)
  );

  sysctl_rdpath #(
    .WA_W       (WA_W),
    .DATA_W     (DATA_W),
    .NUM_STAT   (NUM_STAT),
    .STAT_WADDRS(STAT_WADDRS),
    .FORCE_MASK (FORCE_MASK)
  ) u_rdpath (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .rd_waddr(waddr),
    .word_in (stored_word),
    .rdata   (bus_rdata)
  );

endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_STAT = 3,
  parameter logic [ADDR_W-1:0] CMD_OFFSET = 12'hF00,
  parameter logic [NUM_STAT*ADDR_W-1:0] STAT_OFFSETS = {12'h10C, 12'h108, 12'h100},
  parameter logic [DATA_W-1:0] FORCE_MASK = 32'h3000_0000
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              sys_reset_req,
  input logic              sys_halt_req
);
  logic cmd_wr;
  logic rd_take;
  logic stat_rd;

  assign cmd_wr  = bus_sel && bus_write && (bus_addr[ADDR_W-1:2] == CMD_OFFSET[ADDR_W-1:2]);
  assign rd_take = bus_sel && !bus_write;

  always_comb begin
    stat_rd = 1'b0;
    for (int k = 0; k < NUM_STAT; k++) begin
      if (bus_addr[ADDR_W-1:2] == STAT_OFFSETS[k*ADDR_W + 2 +: ADDR_W-2]) stat_rd = rd_take;
    end
  end

  AST_RESTART_PULSE: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && (bus_wdata == 1 || bus_wdata == 2)) |=> sys_reset_req); // R3
  AST_RESTART_SOURCE: assert property (@(posedge clk) disable iff (rst)
    sys_reset_req |-> $past(cmd_wr)); // R3
  AST_HALT_PULSE: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && bus_wdata == 3) |=> sys_halt_req); // R4
  AST_HALT_SOURCE: assert property (@(posedge clk) disable iff (rst)
    sys_halt_req |-> $past(cmd_wr)); // R4
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(sys_reset_req && sys_halt_req)); // R4
  AST_STATUS_FORCED: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> ((bus_rdata & FORCE_MASK) == FORCE_MASK)); // R6
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_take |=> $stable(bus_rdata)); // R2

endmodule

bind sysctl_regfile sysctl_regfile_chk #(
  .ADDR_W      (ADDR_W),
  .DATA_W      (DATA_W),
  .NUM_STAT    (NUM_STAT),
  .CMD_OFFSET  (CMD_OFFSET),
  .STAT_OFFSETS(STAT_OFFSETS),
  .FORCE_MASK  (FORCE_MASK)
) u_chk (.*);

// File: tb/tb_sysctl_regfile.sv
module tb_sysctl_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sys_reset_req;
  logic        sys_halt_req;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [31:0] shadow [512];
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic [31:0] last_exp;

  always #10 clk = ~clk;  // 50 MHz

  sysctl_regfile dut (.*);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Model of the power-on contents (R8).
  task automatic model_reset();
    for (int i = 0; i < 512; i++) shadow[i] = 32'h0;
    shadow[9'h40] = 32'h05F2_0121;
    shadow[9'h41] = 32'h0000_0002;
    shadow[9'h42] = 32'h05F3_0121;
    shadow[9'h43] = 32'h05F4_0121;
  endtask

  function automatic logic [31:0] model_read(input logic [11:0] a);
    logic [31:0] v;
    v = shadow[a[10:2]];
    if (a[11:2] == 10'h040 || a[11:2] == 10'h042 || a[11:2] == 10'h043)
      v = v | 32'h3000_0000;
    return v;
  endfunction

  task automatic rd(input logic [11:0] a, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_write = 1'b0; bus_addr = a;
    exp_q.push_back(model_read(a));
    tag_q.push_back(tag);
    last_exp = model_read(a);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d,
                    input logic er, input logic eh, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    shadow[a[10:2]] = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_write = 1'b0;
    chk({tag, " restart"}, {31'b0, sys_reset_req}, {31'b0, er});
    chk({tag, " halt"}, {31'b0, sys_halt_req}, {31'b0, eh});
    if (er || eh) begin
      @(negedge clk);
      chk({tag, " pulse width"}, {30'b0, sys_reset_req, sys_halt_req}, 32'h0);
    end
  endtask

  // Monitor: a read taken at a rising edge is compared half a cycle later.
  initial begin
    forever begin
      @(posedge clk);
      if (!rst && bus_sel && !bus_write) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          chk("scoreboard empty", bus_rdata, 32'hx);
        end else begin
          chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (4) @(negedge clk);
    chk("R9 rdata in reset", bus_rdata, 32'h0);
    chk("R9 pulses in reset", {30'b0, sys_reset_req, sys_halt_req}, 32'h0);
    rst = 1'b0;

    // Power-on values and forced status bits.
    rd(12'h100, "R8 R6 id word 0x100");
    rd(12'h104, "R8 R7 id word 0x104 raw");
    rd(12'h108, "R8 R6 id word 0x108");
    rd(12'h10C, "R8 R6 id word 0x10C");
    rd(12'h110, "R8 zero word 0x110");
    rd(12'h7FC, "R8 zero word 0x7FC");
    rd(12'h0FC, "R7 neighbour 0x0FC raw");

    // Raw stored value on non-status words; overlay not stored.
    wr(12'h104, 32'h0000_0000, 1'b0, 1'b0, "R7 write 0x104");
    rd(12'h104, "R7 0x104 returns stored zero");
    wr(12'h100, 32'h0000_0000, 1'b0, 1'b0, "R6 write 0x100");
    rd(12'h100, "R6 0x100 forced bits");
    rd(12'h900, "R6 R1 alias 0x900 raw");
    wr(12'h108, 32'hCFFF_FFFF, 1'b0, 1'b0, "R6 write 0x108");
    rd(12'h108, "R6 0x108 all ones after overlay");
    rd(12'h908, "R6 alias 0x908 raw");

    // Byte-lane bits ignored, aliasing of upper half.
    wr(12'h023, 32'hA5A5_1234, 1'b0, 1'b0, "R1 write 0x023");
    rd(12'h021, "R1 read 0x021");
    rd(12'h820, "R1 alias 0x820");
    wr(12'hFFC, 32'h1357_9BDF, 1'b0, 1'b0, "R1 write 0xFFC");
    rd(12'h7FC, "R1 alias 0x7FC");

    // Command word.
    wr(12'hF00, 32'd1, 1'b1, 1'b0, "R3 cmd 1");
    wr(12'hF00, 32'd2, 1'b1, 1'b0, "R3 cmd 2");
    wr(12'hF00, 32'd3, 1'b0, 1'b1, "R4 cmd 3");
    wr(12'hF00, 32'd4, 1'b0, 1'b0, "R4 cmd 4 none");
    wr(12'hF00, 32'h0000_0101, 1'b0, 1'b0, "R4 cmd 0x101 none");
    wr(12'hF00, 32'd0, 1'b0, 1'b0, "R4 cmd 0 none");
    wr(12'hF04, 32'd1, 1'b0, 1'b0, "R3 non-command 0xF04");
    wr(12'h700, 32'd2, 1'b0, 1'b0, "R3 alias 0x700 no pulse");
    wr(12'hF00, 32'h0000_0003, 1'b0, 1'b1, "R5 store cmd 3");
    rd(12'hF00, "R5 read back 0xF00");
    rd(12'h700, "R5 R1 alias 0x700");

    // Read data holds while idle.
    rd(12'h020, "R2 read 0x020");
    repeat (5) @(negedge clk);
    chk("R2 rdata holds", bus_rdata, last_exp);

    // Mid-run reset restores power-on values.
    wr(12'h10C, 32'h0000_FFFF, 1'b0, 1'b0, "R9 write 0x10C");
    @(negedge clk);
    rst = 1'b1;
    bus_sel = 1'b1; bus_write = 1'b1; bus_addr = 12'h110; bus_wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    bus_sel = 1'b0; bus_write = 1'b0;
    @(negedge clk);
    chk("R9 rdata cleared", bus_rdata, 32'h0);
    rst = 1'b0;
    model_reset();
    rd(12'h10C, "R9 0x10C back to id");
    rd(12'h020, "R9 0x020 back to zero");
    rd(12'h110, "R9 write during reset ignored");
    rd(12'h104, "R9 0x104 back to id");

    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule